// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the integer general registers of a 64-bit core. It has one write port and two combinational read ports. A privileged-mode input controls a small alternate bank. While that input is high, a fixed and non-contiguous group of register numbers is steered to an 8-entry shadow bank instead of the main array. Privileged handler code can then use scratch registers without saving the interrupted program's values. While the input is low, every register number reaches the main array.

Register number 31 is a hardwired zero. A read in the same cycle as a write to the same register returns the data being written, so a single-cycle pipeline can write back and read operands in one cycle without a separate forwarding path. Which physical entry a number reaches depends only on the mode input in the current cycle, and reads and writes follow the same steering.

Top module: `bankedRegFile`

## Requirements
- R1: Each of register numbers 0 to 30 stores 64 bits. A value written to a number is read back unchanged on either read port in later cycles, until that same physical entry is written again.
- R2: While privMode is 1, register numbers 8, 9, 10, 11, 12, 13 and 14 reach shadow entries 0 to 6 in that order. Writes to them leave the main-array values of those numbers unchanged.
- R3: While privMode is 1, register number 25 reaches shadow entry 7. Main register 25 is neither read nor written.
- R4: While privMode is 0, numbers 8 to 14 and 25 reach the main array. The shadow bank keeps its contents and becomes visible again when privMode returns to 1.
- R5: The steering is the same for the write port and both read ports. The two read ports are independent and may address any numbers in the same cycle.
- R6: Register number 31 always reads 0 on both ports, and a write to it changes no stored value.
- R7: When wrEn is 1 and a read port addresses wrAddr (not 31) in the same cycle, that port returns wrData in that cycle. This holds for shadow entries as well as main entries.
- R8: A clock edge with rst high (synchronous, active high) clears all 31 main entries and all 8 shadow entries to 0.
- R9: Register numbers 0 to 7, 15 to 24 and 26 to 30 reach the same main entry whatever the value of privMode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of all entries |
| privMode | input | 1 | Selects shadow steering for the banked numbers |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Register number written |
| wrData | input | 64 | Write data |
| rdAddrA | input | 5 | Register number for read port A |
| rdDataA | output | 64 | Read port A data, combinational |
| rdAddrB | input | 5 | Register number for read port B |
| rdDataB | output | 64 | Read port B data, combinational |

## Verification
Full sweeps write distinct patterns through the main array and then through the shadow bank, and read every number back under both mode values. This separates a missing remap, a wrong shadow index, and a remap that wrongly covers neighbouring numbers such as 7, 15, 24 or 26. Same-cycle write/read pairs on main numbers, banked numbers and number 31 show whether the bypass compares the steered entry and whether it wrongly fires on the zero register. A long pseudo-random mix of mode toggles, writes and dual reads, followed by a reset in the middle of the run, is compared every cycle against a behavioural model. This catches port cross-talk and reset that misses part of the storage.

// File: rtl/bankRegPkg.sv
package bankRegPkg;
  // storage geometry
  parameter int DATA_W       = 64;
  parameter int ADDR_W       = 5;
  parameter int NUM_RD       = 2;
  parameter int MAIN_CNT     = (1 << ADDR_W) - 1;
  parameter int ZERO_REG     = (1 << ADDR_W) - 1;
  // shadow steering: a contiguous run plus one extra number
  parameter int SHADOW_BASE  = 8;
  parameter int SHADOW_RUN   = 7;
  parameter int SHADOW_EXTRA = 25;
  parameter int SHADOW_CNT   = SHADOW_RUN + 1;
  parameter int SHADOW_IDX_W = $clog2(SHADOW_CNT);

  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_MAIN   = 2'd1,
    SRC_SHADOW = 2'd2
  } srcSel_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic                           wrMain;
    logic                           wrShadow;
    logic [ADDR_W-1:0]              wrIdx;
    srcSel_t [NUM_RD-1:0]           rdSrc;
    logic [NUM_RD-1:0][ADDR_W-1:0]  rdIdx;
    logic [NUM_RD-1:0]              rdBypass;
  } ctlStrobes_t;
endpackage

// File: rtl/bankMapCtl.sv
module bankMapCtl
  import bankRegPkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          privMode,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  output ctlStrobes_t                   strobes
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(SHADOW_BASE);
  localparam logic [ADDR_W-1:0] END_A   = ADDR_W'(SHADOW_BASE + SHADOW_RUN);
  localparam logic [ADDR_W-1:0] EXTRA_A = ADDR_W'(SHADOW_EXTRA);
  localparam logic [ADDR_W-1:0] ZERO_A  = ADDR_W'(ZERO_REG);
  localparam logic [ADDR_W-1:0] EXTRA_I = ADDR_W'(SHADOW_RUN);

  typedef struct packed {
    srcSel_t           src;
    logic [ADDR_W-1:0] idx;
  } target_t;

  function automatic target_t steer(input logic [ADDR_W-1:0] num, input logic priv);
    target_t t;
    if (num == ZERO_A) begin
      t.src = SRC_ZERO;
      t.idx = '0;
    end else if (priv && num >= BASE_A && num < END_A) begin
      t.src = SRC_SHADOW;
      t.idx = num - BASE_A;
    end else if (priv && num == EXTRA_A) begin
      t.src = SRC_SHADOW;
      t.idx = EXTRA_I;
    end else begin
      t.src = SRC_MAIN;
      t.idx = num;
    end
    return t;
  endfunction

  target_t wrTgt;

  always_comb begin
    wrTgt            = steer(wrAddr, privMode);
    strobes.wrMain   = wrEn && (wrTgt.src == SRC_MAIN);
    strobes.wrShadow = wrEn && (wrTgt.src == SRC_SHADOW);
    strobes.wrIdx    = wrTgt.idx;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    target_t rdTgt;
    always_comb begin
      rdTgt               = steer(rdAddr[p], privMode);
      strobes.rdSrc[p]    = rdTgt.src;
      strobes.rdIdx[p]    = rdTgt.idx;
      // bypass compares steered physical targets, never the zero register
      strobes.rdBypass[p] = wrEn && (rdTgt.src != SRC_ZERO) &&
                            (rdTgt.src == wrTgt.src) && (rdTgt.idx == wrTgt.idx);
    end
  end

  AST_WR_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.wrMain, strobes.wrShadow})); // R5
  AST_CLEAR_NO_SHADOW: assert property (@(posedge clk) disable iff (rst)
    !privMode |-> !strobes.wrShadow); // R4
  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrAddr == ZERO_A) |-> !(strobes.wrMain || strobes.wrShadow)); // R6
endmodule

// File: rtl/bankRegStore.sv
module bankRegStore
  import bankRegPkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  ctlStrobes_t                   strobes,
  input  logic [DATA_W-1:0]             wrData,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mainQ   [MAIN_CNT];
  logic [DATA_W-1:0] shadowQ [SHADOW_CNT];

  for (genvar i = 0; i < MAIN_CNT; i++) begin : g_main
    always_ff @(posedge clk) begin
      if (rst)
        mainQ[i] <= '0;
      else if (strobes.wrMain && strobes.wrIdx == ADDR_W'(i))
        mainQ[i] <= wrData;
    end
  end

  for (genvar s = 0; s < SHADOW_CNT; s++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)
        shadowQ[s] <= '0;
      else if (strobes.wrShadow && strobes.wrIdx == ADDR_W'(s))
        shadowQ[s] <= wrData;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(strobes.wrShadow && strobes.wrIdx == ADDR_W'(s)) |=> $stable(shadowQ[s])); // R4
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdMux
    always_comb begin
      if (strobes.rdBypass[p])
        rdData[p] = wrData;
      else begin
        unique case (strobes.rdSrc[p])
          SRC_MAIN:   rdData[p] = mainQ[strobes.rdIdx[p]];
          SRC_SHADOW: rdData[p] = shadowQ[strobes.rdIdx[p][SHADOW_IDX_W-1:0]];
          default:    rdData[p] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankRegPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                privMode,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddrA,
  output logic [DATA_W-1:0]   rdDataA,
  input  logic [ADDR_W-1:0]   rdAddrB,
  output logic [DATA_W-1:0]   rdDataB
);
  localparam logic [ADDR_W-1:0] ZERO_A = ADDR_W'(ZERO_REG);

  ctlStrobes_t                   strobes;
  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  bankMapCtl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .privMode(privMode),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .strobes (strobes)
  );

  bankRegStore u_store (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .wrData (wrData),
    .rdData (rdData)
  );

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == ZERO_A) |-> (rdDataA == '0)); // R6
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == ZERO_A) |-> (rdDataB == '0)); // R6
  AST_RAW_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != ZERO_A && rdAddrA == wrAddr) |-> (rdDataA == wrData)); // R7
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != ZERO_A) |=>
      ((rdAddrB == $past(wrAddr) && privMode == $past(privMode) &&
        !(wrEn && wrAddr == rdAddrB)) -> (rdDataB == $past(wrData)))); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wrEn) |-> (rdDataA == '0 && rdDataB == '0)); // R8
endmodule

// File: tb/bankedRegFile_tb.sv
module bankedRegFile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        privMode;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [63:0] wrData;
  logic [4:0]  rdAddrA;
  logic [63:0] rdDataA;
  logic [4:0]  rdAddrB;
  logic [63:0] rdDataB;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [63:0] mM [31];
  logic [63:0] sM [8];
  logic [31:0] lfsr = 32'hACE1_2357;

  bankedRegFile u_dut (
    .clk(clk), .rst(rst), .privMode(privMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  always #5 clk = ~clk;

  // shadow slot for a number under the mode, -1 if main, -2 if zero
  function automatic int slotOf(input int num, input bit priv);
    if (num == 31) return -2;
    if (priv && num >= 8 && num <= 14) return num - 8;
    if (priv && num == 25) return 7;
    return -1;
  endfunction

  function automatic logic [63:0] modelRead(input int num, input bit priv,
                                            input bit we, input int wa,
                                            input logic [63:0] wd);
    int sl;
    sl = slotOf(num, priv);
    if (sl == -2) return 64'd0;
    if (we && wa == num) return wd;
    if (sl >= 0) return sM[sl];
    return mM[num];
  endfunction

  task automatic clearModel();
    for (int i = 0; i < 31; i++) mM[i] = 64'd0;
    for (int i = 0; i < 8; i++) sM[i] = 64'd0;
  endtask

  task automatic check(input string tag, input string port, input int num,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s port %s reg %0d priv %0d: got %h expected %h",
               tag, port, num, privMode, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, update model at posedge
  task automatic step(input string tag, input bit priv, input bit we, input int wa,
                      input logic [63:0] wd, input int ra, input int rb);
    int sl;
    @(negedge clk);
    privMode = priv; wrEn = we; wrAddr = 5'(wa); wrData = wd;
    rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    #1;
    check(tag, "A", ra, rdDataA, modelRead(ra, priv, we, wa, wd));
    check(tag, "B", rb, rdDataB, modelRead(rb, priv, we, wa, wd));
    @(posedge clk);
    if (we) begin
      sl = slotOf(wa, priv);
      if (sl >= 0) sM[sl] = wd;
      else if (sl == -1) mM[wa] = wd;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; wrAddr = 5'd3; wrData = '1;
    @(posedge clk);
    clearModel();
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
  endtask

  task automatic sweep(input string tag, input bit priv);
    for (int a = 0; a < 32; a++) step(tag, priv, 1'b0, 0, 64'd0, a, 31 - a);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; privMode = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    rdAddrA = '0; rdAddrB = '0;
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R8: everything zero after reset, both modes
    sweep("R8", 1'b0);
    sweep("R8", 1'b1);

    // R1/R4/R9: fill main array with flag clear; R6: write to 31 discarded
    for (int a = 0; a < 31; a++)
      step("R1", 1'b0, 1'b1, a, {32'hA0A0_0000 + 32'(a), 32'h1234_5678 ^ 32'(a)}, a, 31);
    step("R6", 1'b0, 1'b1, 31, 64'hDEAD_BEEF_F00D_CAFE, 31, 31);
    sweep("R6", 1'b0);

    // R2/R3: banked numbers written with flag set go to shadow
    for (int a = 8; a <= 14; a++)
      step("R2", 1'b1, 1'b1, a, {32'h5A5A_0000 + 32'(a), 32'hFFFF_0000}, 7, 15);
    step("R3", 1'b1, 1'b1, 25, 64'h2525_2525_0000_0007, 24, 26);
    sweep("R2", 1'b1);
    sweep("R4", 1'b0);
    sweep("R3", 1'b1);

    // R9: non-banked numbers written with flag set land in main
    for (int a = 0; a < 31; a++)
      if (slotOf(a, 1'b1) == -1)
        step("R9", 1'b1, 1'b1, a, {32'h9999_0000 + 32'(a), 32'(a * 3)}, 25, a);
    sweep("R9", 1'b0);

    // R7: same-cycle bypass on main, shadow and zero register
    step("R7", 1'b0, 1'b1, 12, 64'h0BAD_0012_0000_0001, 12, 12);
    step("R7", 1'b1, 1'b1, 12, 64'h0BAD_0012_0000_0002, 12, 13);
    step("R7", 1'b1, 1'b1, 25, 64'h0BAD_0025_0000_0003, 8, 25);
    step("R7", 1'b0, 1'b1, 25, 64'h0BAD_0025_0000_0004, 25, 24);
    step("R7", 1'b1, 1'b1, 31, 64'h0BAD_0031_0000_0005, 31, 31);
    step("R7", 1'b1, 1'b1, 3, 64'h0BAD_0003_0000_0006, 3, 3);
    sweep("R7", 1'b1);
    sweep("R7", 1'b0);

    // R5: random mix of modes, writes and dual reads
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R5", lfsr[3], lfsr[7] | lfsr[9], int'(lfsr[14:10]),
           {lfsr, ~lfsr ^ 32'(n)}, int'(lfsr[19:15]), int'(lfsr[24:20]));
    end

    // R8: reset mid-run clears main and shadow
    doReset();
    sweep("R8", 1'b1);
    sweep("R8", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule